// File: doc/BRIEF.md
# SD Command Issue Register Engine

This block is the command half of an SD host controller. Software programs an argument word and a timeout limit over a 32-bit register bus, then writes a command word whose top bit starts the command. The engine presents the command index, argument and expected response kind to an abstract card-command port for one cycle. It then collects zero, one or four 32-bit response words from that port. A CRC check on the final word and a programmable response timeout decide whether the command succeeded.

The start bit in the command word reads back as 1 for as long as the command is outstanding and drops by itself when the engine is done, so software detects completion by polling. A failure flag in the same word and two sticky status bits (timeout, CRC) report the outcome. The status bits are cleared by writing ones to them. A busy-wait option holds completion until the card releases its busy line after the response.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset the command word reads 0, the argument reads 0, the timeout limit reads 0x00F00000, the status word reads 0 and all four response words read 0.
- R2: A write to offset 0x00 with bit 15 set, while bit 15 reads 0, starts a command. Bit 15 then reads 1 until the command ends and reads 0 afterwards. The launch shows the command index (bits 5:0) on `cardCmdIndex`, the argument register on `cardCmdArg`, and the response kind on `cardRespKind`: 0 for none (bit 10 set), 2 for long (bit 9 set), 1 otherwise.
- R3: Each command raises `cardCmdValid` for exactly one clock cycle.
- R4: For a short response, the single word returned is stored in response word 0 (offset 0x10), and words 1 to 3 (0x14, 0x18, 0x1C) keep their values.
- R5: For a long response, four words are returned and stored in arrival order at offsets 0x10, 0x14, 0x18 and 0x1C.
- R6: A command with bit 10 set completes without waiting and never sets the failed bit (14) or a status bit. Response words arriving during or after such a command leave the response registers unchanged.
- R7: If no response word arrives for more than the number of cycles held in the timeout register (offset 0x08), the engine ends the command and sets status bit 6 (offset 0x20) and command bit 14.
- R8: If the CRC-error input is high with the final response word, the engine sets status bit 4 and command bit 14.
- R9: With command bit 11 set, bit 15 stays 1 after the final response word until `cardBusy` is low.
- R10: A write to the command word while bit 15 reads 1 has no effect.
- R11: Status bits are write-one-to-clear; writing 0xFFFF to offset 0x20 clears them. The failed bit 14 is cleared when the next command is launched.
- R12: The argument (0x04) and timeout (0x08) registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data (combinational from busAddr) |
| cardCmdValid | output | 1 | One-cycle command launch strobe |
| cardCmdIndex | output | 6 | Command index |
| cardCmdArg | output | 32 | Command argument |
| cardRespKind | output | 2 | 0 none, 1 short, 2 long |
| cardRespValid | input | 1 | Response word valid |
| cardRespWord | input | 32 | Response word |
| cardRespCrcErr | input | 1 | CRC error flag, read together with the final word |
| cardBusy | input | 1 | Card busy indication |

## Verification
The hardest situation to reach from the ports is a second command write that lands while a command is still outstanding. The bench reaches it by holding back the card's response words after the launch strobe. While the engine waits, the bench writes a different command word, reads the command register to confirm nothing changed, and only then supplies the four words of the long response. The busy-wait hold is reached in a similar way: the bench keeps the card's busy line high for several cycles after the final word and samples the start bit during that window.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int RESP_WORDS = 4;
  localparam int SEL_W      = $clog2(RESP_WORDS);

  localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ARG    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_TMO    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RESP0  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h20;

  localparam logic [DATA_W-1:0] TMO_RESET = 32'h00F0_0000;

  // command word bit positions
  localparam int BIT_EN    = 15;
  localparam int BIT_FAIL  = 14;
  localparam int BIT_BUSY  = 11;
  localparam int BIT_NONE  = 10;
  localparam int BIT_LONG  = 9;
  localparam int BIT_WR    = 7;
  localparam int BIT_RD    = 6;
  // status bit positions
  localparam int ST_TMO = 6;
  localparam int ST_CRC = 4;

  typedef enum logic [1:0] {KIND_NONE = 2'd0, KIND_SHORT = 2'd1, KIND_LONG = 2'd2} resp_kind_e;

  typedef struct packed {
    logic             capture;
    logic [SEL_W-1:0] wordSel;
    logic             setTimeout;
    logic             setCrcErr;
    logic             finish;
  } ctrl_strobe_t;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEnable,
  input  logic              respNone,
  input  logic              respLong,
  input  logic              busyWait,
  input  logic [DATA_W-1:0] timeoutLimit,
  input  logic              cardRespValid,
  input  logic              cardRespCrcErr,
  input  logic              cardBusy,
  output logic              cardCmdValid,
  output ctrl_strobe_t      strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_BUSYW} state_e;

  state_e            state, nextState;
  logic [SEL_W-1:0]  beatCnt;
  logic [DATA_W-1:0] tmr;
  logic              lastBeat;

  assign lastBeat     = respLong ? (beatCnt == SEL_W'(RESP_WORDS - 1)) : 1'b1;
  assign cardCmdValid = (state == ST_ISSUE);

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE:  if (cmdEnable) nextState = ST_ISSUE;
      ST_ISSUE: begin
        if (respNone) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cardRespValid) begin
          strb.capture = 1'b1;
          strb.wordSel = beatCnt;
          if (lastBeat) begin
            strb.setCrcErr = cardRespCrcErr;
            if (busyWait) begin
              nextState = ST_BUSYW;
            end else begin
              strb.finish = 1'b1;
              nextState   = ST_IDLE;
            end
          end
        end else if (tmr >= timeoutLimit) begin
          strb.setTimeout = 1'b1;
          strb.finish     = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      ST_BUSYW: begin
        if (!cardBusy) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      tmr     <= '0;
    end else begin
      state <= nextState;
      if (state == ST_ISSUE) begin
        beatCnt <= '0;
        tmr     <= '0;
      end else if (state == ST_WAIT) begin
        if (cardRespValid) begin
          beatCnt <= beatCnt + 1'b1;
          tmr     <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  // R3: launch strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cardCmdValid |=> !cardCmdValid);
  // R2: engine only works while the start bit is held
  a_r2_enable_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> cmdEnable);
  // R6: no capture or timeout for a command without response
  a_r6_none_quiet: assert property (@(posedge clk) disable iff (!rstN)
    respNone |-> !(strb.capture || strb.setTimeout || strb.setCrcErr));
  // R9: no completion while the card is busy in busy-wait
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSYW && cardBusy) |-> !strb.finish);
endmodule

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
  import sd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  ctrl_strobe_t      strb,
  input  logic [DATA_W-1:0] respWord,
  output logic              cmdEnable,
  output logic              respNone,
  output logic              respLong,
  output logic              busyWait,
  output logic [5:0]        cmdIndex,
  output logic [DATA_W-1:0] argValue,
  output logic [DATA_W-1:0] timeoutLimit
);
  logic              cmdFailed, cmdWrFlag, cmdRdFlag;
  logic              stTmo, stCrc;
  logic [DATA_W-1:0] respReg [RESP_WORDS];
  logic              cmdWrite, cmdAccept, statusWrite;
  logic [DATA_W-1:0] cmdView;

  assign cmdWrite    = busWrEn && (busAddr == OFS_CMD);
  assign cmdAccept   = cmdWrite && !cmdEnable;
  assign statusWrite = busWrEn && (busAddr == OFS_STATUS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdEnable    <= 1'b0;
      cmdFailed    <= 1'b0;
      busyWait     <= 1'b0;
      respNone     <= 1'b0;
      respLong     <= 1'b0;
      cmdWrFlag    <= 1'b0;
      cmdRdFlag    <= 1'b0;
      cmdIndex     <= '0;
      argValue     <= '0;
      timeoutLimit <= TMO_RESET;
      stTmo        <= 1'b0;
      stCrc        <= 1'b0;
    end else begin
      if (cmdAccept) begin
        cmdEnable <= busWrData[BIT_EN];
        busyWait  <= busWrData[BIT_BUSY];
        respNone  <= busWrData[BIT_NONE];
        respLong  <= busWrData[BIT_LONG];
        cmdWrFlag <= busWrData[BIT_WR];
        cmdRdFlag <= busWrData[BIT_RD];
        cmdIndex  <= busWrData[5:0];
        if (busWrData[BIT_EN]) cmdFailed <= 1'b0;
      end else begin
        if (strb.finish) cmdEnable <= 1'b0;
        if (strb.setTimeout || strb.setCrcErr) cmdFailed <= 1'b1;
      end
      if (busWrEn && busAddr == OFS_ARG) argValue <= busWrData;
      if (busWrEn && busAddr == OFS_TMO) timeoutLimit <= busWrData;
      stTmo <= strb.setTimeout || (stTmo && !(statusWrite && busWrData[ST_TMO]));
      stCrc <= strb.setCrcErr  || (stCrc && !(statusWrite && busWrData[ST_CRC]));
    end
  end

  for (genvar w = 0; w < RESP_WORDS; w++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rstN) respReg[w] <= '0;
      else if (strb.capture && strb.wordSel == SEL_W'(w)) respReg[w] <= respWord;
    end
  end

  always_comb begin
    cmdView = '0;
    cmdView[BIT_EN]   = cmdEnable;
    cmdView[BIT_FAIL] = cmdFailed;
    cmdView[BIT_BUSY] = busyWait;
    cmdView[BIT_NONE] = respNone;
    cmdView[BIT_LONG] = respLong;
    cmdView[BIT_WR]   = cmdWrFlag;
    cmdView[BIT_RD]   = cmdRdFlag;
    cmdView[5:0]      = cmdIndex;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_CMD:    busRdData = cmdView;
      OFS_ARG:    busRdData = argValue;
      OFS_TMO:    busRdData = timeoutLimit;
      OFS_STATUS: begin
        busRdData[ST_TMO] = stTmo;
        busRdData[ST_CRC] = stCrc;
      end
      default: begin
        for (int w = 0; w < RESP_WORDS; w++)
          if (busAddr == OFS_RESP0 + ADDR_W'(4 * w)) busRdData = respReg[w];
      end
    endcase
  end

  // R10: command fields frozen against writes while a command is pending
  a_r10_cmd_locked: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && cmdWrite) |=> $stable(cmdIndex) && $stable(respLong) && $stable(respNone));
  // R11: writing one to the timeout status bit clears it
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrite && busWrData[ST_TMO] && !strb.setTimeout) |=> !stTmo);
  // R7: a timeout marks the command as failed
  a_r7_timeout_fails: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTimeout |=> (cmdFailed && stTmo && !cmdEnable));
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        cardCmdValid,
  output logic [5:0]  cardCmdIndex,
  output logic [31:0] cardCmdArg,
  output logic [1:0]  cardRespKind,
  input  logic        cardRespValid,
  input  logic [31:0] cardRespWord,
  input  logic        cardRespCrcErr,
  input  logic        cardBusy
);
  ctrl_strobe_t      strb;
  logic              cmdEnable, respNone, respLong, busyWait;
  logic [DATA_W-1:0] timeoutLimit;

  sd_cmd_regs u_regs (
    .clk, .rstN, .busAddr, .busWrEn, .busWrData, .busRdData,
    .strb, .respWord(cardRespWord),
    .cmdEnable, .respNone, .respLong, .busyWait,
    .cmdIndex(cardCmdIndex), .argValue(cardCmdArg), .timeoutLimit
  );

  sd_cmd_ctrl u_ctrl (
    .clk, .rstN, .cmdEnable, .respNone, .respLong, .busyWait, .timeoutLimit,
    .cardRespValid, .cardRespCrcErr, .cardBusy, .cardCmdValid, .strb
  );

  assign cardRespKind = respNone ? KIND_NONE : (respLong ? KIND_LONG : KIND_SHORT);
endmodule

// File: tb/sd_cmd_issue_bench.sv
module sd_cmd_issue_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        cardCmdValid;
  logic [5:0]  cardCmdIndex;
  logic [31:0] cardCmdArg;
  logic [1:0]  cardRespKind;
  logic        cardRespValid = 1'b0;
  logic [31:0] cardRespWord = '0;
  logic        cardRespCrcErr = 1'b0;
  logic        cardBusy = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [31:0] respModel [4];

  always #5 clk = ~clk;

  sd_cmd_issue u_sd_cmd_issue (.*);

  typedef struct packed {
    logic [15:0] cmd;
    logic [31:0] arg;
    logic [2:0]  beats;
    logic        crc;
    logic [7:0]  expStatus;
    logic        expFail;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'h8051, 32'h0000_1234, 3'd1, 1'b0, 8'h00, 1'b0},  // short read
    '{16'h8202, 32'h0000_0000, 3'd4, 1'b0, 8'h00, 1'b0},  // long
    '{16'h8003, 32'h0055_0000, 3'd1, 1'b1, 8'h10, 1'b1},  // crc error
    '{16'h8400, 32'h0000_0000, 3'd0, 1'b0, 8'h00, 1'b0},  // no response
    '{16'h8008, 32'h0000_01AA, 3'd0, 1'b0, 8'h40, 1'b1},  // timeout
    '{16'h8098, 32'hDEAD_BEEF, 3'd1, 1'b0, 8'h00, 1'b0}   // short write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic waitLaunch(output bit seen);
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (cardCmdValid) seen = 1;
      else @(negedge clk);
    end
  endtask

  task automatic driveBeats(input int n, input logic [31:0] base, input logic crcLast);
    for (int k = 0; k < n; k++) begin
      cardRespValid  = 1'b1;
      cardRespWord   = base + 32'(k);
      cardRespCrcErr = crcLast && (k == n - 1);
      @(negedge clk);
    end
    cardRespValid = 1'b0; cardRespCrcErr = 1'b0;
  endtask

  task automatic waitDone(output bit done);
    logic [31:0] d;
    done = 0;
    for (int i = 0; i < 200 && !done; i++) begin
      busRead(8'h00, d);
      if (!d[15]) done = 1;
      else @(negedge clk);
    end
  endtask

  task automatic checkResp(input string req);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      busRead(8'h10 + 8'(4 * w), d);
      chk(req, d, respModel[w]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] base;
    bit seen, done;
    for (int w = 0; w < 4; w++) respModel[w] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    busRead(8'h00, d); chk("R1 cmd", d, 32'h0);
    busRead(8'h04, d); chk("R1 arg", d, 32'h0);
    busRead(8'h08, d); chk("R1 timeout", d, 32'h00F0_0000);
    busRead(8'h20, d); chk("R1 status", d, 32'h0);
    checkResp("R1 resp");

    // R12 timeout register
    busWrite(8'h08, 32'd40);
    busRead(8'h08, d); chk("R12 timeout readback", d, 32'd40);

    // table-driven commands
    for (int v = 0; v < NVEC; v++) begin
      base = 32'hA000_0000 + 32'(v * 16);
      busWrite(8'h04, VECS[v].arg);
      busRead(8'h04, d); chk("R12 arg readback", d, VECS[v].arg);
      busWrite(8'h00, {16'h0, VECS[v].cmd});
      waitLaunch(seen);
      chk("R2 launch seen", 32'(seen), 32'd1);
      chk("R2 index", 32'(cardCmdIndex), 32'(VECS[v].cmd[5:0]));
      chk("R2 arg", cardCmdArg, VECS[v].arg);
      chk("R2 kind", 32'(cardRespKind),
          VECS[v].cmd[10] ? 32'd0 : (VECS[v].cmd[9] ? 32'd2 : 32'd1));
      @(negedge clk);
      chk("R3 single pulse", 32'(cardCmdValid), 32'd0);
      driveBeats(int'(VECS[v].beats), base, VECS[v].crc);
      for (int k = 0; k < int'(VECS[v].beats); k++) respModel[k] = base + 32'(k);
      waitDone(done);
      chk("R2 enable clears", 32'(done), 32'd1);
      checkResp(VECS[v].beats == 3'd4 ? "R5 long words" : "R4 short word");
      busRead(8'h20, d); chk("R7 R8 status", d, 32'(VECS[v].expStatus));
      busRead(8'h00, d); chk("R11 failed bit", 32'(d[14]), 32'(VECS[v].expFail));
      busWrite(8'h20, 32'h0000_FFFF);
      busRead(8'h20, d); chk("R11 status cleared", d, 32'h0);
    end

    // R6: stray response words around a no-response command are ignored
    busWrite(8'h00, 32'h0000_8400);
    cardRespValid = 1'b1; cardRespWord = 32'h1111_2222;
    repeat (4) @(negedge clk);
    cardRespValid = 1'b0;
    waitDone(done);
    chk("R6 none done", 32'(done), 32'd1);
    checkResp("R6 resp unchanged");
    busRead(8'h00, d); chk("R6 not failed", 32'(d[14]), 32'd0);

    // R10: command write while pending is ignored
    busWrite(8'h00, 32'h0000_8209);
    waitLaunch(seen);
    @(negedge clk);
    busWrite(8'h00, 32'h0000_8411);
    busRead(8'h00, d); chk("R10 cmd unchanged", d, 32'h0000_8209);
    driveBeats(4, 32'hC000_0000, 1'b0);
    for (int k = 0; k < 4; k++) respModel[k] = 32'hC000_0000 + 32'(k);
    waitDone(done);
    chk("R10 completes", 32'(done), 32'd1);
    checkResp("R10 R5 words");
    busRead(8'h00, d); chk("R10 index kept", 32'(d[5:0]), 32'h09);

    // R9: busy-wait holds completion
    busWrite(8'h00, 32'h0000_8807);
    waitLaunch(seen);
    @(negedge clk);
    cardBusy = 1'b1;
    driveBeats(1, 32'hB000_0000, 1'b0);
    respModel[0] = 32'hB000_0000;
    repeat (5) @(negedge clk);
    busRead(8'h00, d); chk("R9 held while busy", 32'(d[15]), 32'd1);
    cardBusy = 1'b0;
    waitDone(done);
    chk("R9 released", 32'(done), 32'd1);
    checkResp("R9 R4 word");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule